// File: doc/BRIEF.md
# Maskable Event Router with Latching

The block collects a set of external event pins and a few on-chip event signals and turns them into one interrupt request and one wake-up request. Each channel is configured by software: a polarity bit picks the active level or edge, a mode bit picks whether the channel follows its input (direct) or captures an edge and holds it (latched), and two enable bits decide whether the channel may drive the interrupt output, the wake output, or both.

External pins are asynchronous and pass through a synchronizer chain before any detection. Internal sources are already synchronous and enter the detector directly. A latched channel stays pending until software writes a one to its bit in the clear register. Software can also force a latched bit through a set register. A clear that lands in the same cycle as a new captured edge loses, so no event is dropped. Both outputs are registered ORs of the pending bits gated by their enables, so they carry no glitches.

The register bus is a simple 32-bit word interface with separate write and read strobes. Read data is registered and appears the cycle after the read strobe. Channel bit n is external pin n for n below the external count. The internal sources follow above the external pins.

Top module: `event_router`

## Requirements
- R1: After reset, irq and wake are 0, and the mask (0x08), polarity (0x0C), mode (0x10) and wake-enable (0x1C) registers read 0.
- R2: Offset 0x00 reads the synchronized input levels. Bits 0..23 are the external pins, bits 24..26 are the internal sources, and bits 27..31 read 0.
- R3: In direct mode (mode bit 0), the channel's pending bit (offset 0x04) is 1 exactly while the input is at its active level. Polarity 1 means high is active; polarity 0 means low is active. The bit drops as soon as the input becomes inactive.
- R4: In latched mode (mode bit 1), the active edge sets the pending bit: rising when polarity is 1, falling when polarity is 0. The bit stays set after the input goes inactive, until a 1 is written to that bit at offset 0x14. Writing 0 there has no effect.
- R5: irq is a registered OR of pending bits ANDed with the mask register. A pending bit whose mask bit is 0 still shows at 0x04 but does not raise irq.
- R6: wake is a registered OR of pending bits ANDed with the wake-enable register at 0x1C, independent of the mask register.
- R7: Writing a 1 to a bit at offset 0x18 sets that channel's latched pending bit, including the highest internal channel (bit 26).
- R8: If a clear write and a new active edge reach the same latched channel in the same cycle, the bit stays pending.
- R9: bus_rdata is loaded on the clock edge that samples bus_rd high and holds its value while bus_rd is low.
- R10: The mask, polarity, mode and wake-enable registers read back the written value in bits 0..26, with bits 27..31 reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_ev | input | 24 | Asynchronous external event pins |
| int_ev | input | 3 | Synchronous internal event sources |
| bus_addr | input | 5 | Byte address of the register word |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered interrupt request |
| wake | output | 1 | Registered wake-up request |

## Verification
The bench builds the block with its default parameters: 24 external pins, 3 internal sources and a two-stage synchronizer. This puts the top external channel (bit 23) and the top internal channel (bit 26) within reach of directed tests, and shows the unused upper bits of every register. The internal sources have no synchronizer, so the bench can line up a new edge with a clear write on the same clock edge and test the edge-wins rule exactly. The external pins are used for the polarity and mode cases, and enough cycles are allowed for the synchronizer and output registers.

// File: rtl/evr_pkg.sv
package evr_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        SEL_RAW  = 3'd0,
        SEL_PEND = 3'd1,
        SEL_MASK = 3'd2,
        SEL_POL  = 3'd3,
        SEL_MODE = 3'd4,
        SEL_CLR  = 3'd5,
        SEL_SET  = 3'd6,
        SEL_WAKE = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic irq_en;
        logic wake_en;
        logic act_high;
        logic latched;
    } chan_cfg_t;

    function automatic reg_sel_e sel_of(input logic [2:0] word);
        return reg_sel_e'(word);
    endfunction

endpackage

// File: rtl/evr_sync.sv
module evr_sync #(
    parameter int W      = 24,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/evr_detect.sv
module evr_detect
    import evr_pkg::*;
#(
    parameter int N = 27
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N-1:0]          lvl,
    input  chan_cfg_t [N-1:0]     cfg,
    input  logic [N-1:0]          clr_stb,
    input  logic [N-1:0]          set_stb,
    output logic [N-1:0]          pending,
    output logic [N-1:0]          lat,
    output logic [N-1:0]          edge_set
);
    logic [N-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= lvl;
    end

    for (genvar c = 0; c < N; c++) begin : g_chan
        logic active, rise, fall, hit, set_now;

        assign rise    = lvl[c] & ~prev[c];
        assign fall    = ~lvl[c] & prev[c];
        assign active  = cfg[c].act_high ? lvl[c] : ~lvl[c];
        assign hit     = cfg[c].act_high ? rise : fall;
        assign edge_set[c] = cfg[c].latched & hit;
        assign set_now = edge_set[c] | set_stb[c];

        always_ff @(posedge clk) begin
            if (rst)          lat[c] <= 1'b0;
            else if (set_now) lat[c] <= 1'b1;
            else if (clr_stb[c]) lat[c] <= 1'b0;
        end

        assign pending[c] = cfg[c].latched ? lat[c] : active;
    end
endmodule

// File: rtl/evr_regs.sv
module evr_regs
    import evr_pkg::*;
#(
    parameter int N      = 27,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [N-1:0]      raw,
    input  logic [N-1:0]      pending,
    output chan_cfg_t [N-1:0] cfg,
    output logic [N-1:0]      clr_stb,
    output logic [N-1:0]      set_stb,
    output logic [DATA_W-1:0] bus_rdata
);
    logic [N-1:0] mask_q, pol_q, mode_q, wake_q;
    logic [N-1:0] wd;
    logic         in_range;
    reg_sel_e     sel;
    logic [DATA_W-1:0] rd_next;
    logic [DATA_W-1:0] unused_wdata;
    logic [ADDR_W-1:0] unused_addr;

    assign unused_wdata = bus_wdata;
    assign unused_addr  = bus_addr;
    assign wd       = bus_wdata[N-1:0];
    assign sel      = sel_of(bus_addr[4:2]);
    assign in_range = (bus_addr >> 5) == '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            pol_q  <= '0;
            mode_q <= '0;
            wake_q <= '0;
        end else if (bus_wr && in_range) begin
            case (sel)
                SEL_MASK: mask_q <= wd;
                SEL_POL:  pol_q  <= wd;
                SEL_MODE: mode_q <= wd;
                SEL_WAKE: wake_q <= wd;
                default:  ;
            endcase
        end
    end

    assign clr_stb = (bus_wr && in_range && sel == SEL_CLR) ? wd : '0;
    assign set_stb = (bus_wr && in_range && sel == SEL_SET) ? wd : '0;

    always_comb begin
        for (int c = 0; c < N; c++) begin
            cfg[c].irq_en   = mask_q[c];
            cfg[c].wake_en  = wake_q[c];
            cfg[c].act_high = pol_q[c];
            cfg[c].latched  = mode_q[c];
        end
    end

    always_comb begin
        rd_next = '0;
        if (in_range) begin
            case (sel)
                SEL_RAW:  rd_next[N-1:0] = raw;
                SEL_PEND: rd_next[N-1:0] = pending;
                SEL_MASK: rd_next[N-1:0] = mask_q;
                SEL_POL:  rd_next[N-1:0] = pol_q;
                SEL_MODE: rd_next[N-1:0] = mode_q;
                SEL_WAKE: rd_next[N-1:0] = wake_q;
                default:  rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end
endmodule

// File: rtl/event_router.sv
module event_router
    import evr_pkg::*;
#(
    parameter int N_EXT       = 24,
    parameter int N_INT       = 3,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_EXT-1:0]  ext_ev,
    input  logic [N_INT-1:0]  int_ev,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              wake
);
    localparam int N = N_EXT + N_INT;

    logic [N_EXT-1:0]  ext_s;
    logic [N-1:0]      lvl, pending, lat_q, edge_set, clr_stb, set_stb;
    logic [N-1:0]      irq_en_v, wake_en_v;
    chan_cfg_t [N-1:0] cfg;

    evr_sync #(.W(N_EXT), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(ext_ev), .q(ext_s)
    );

    assign lvl = {int_ev, ext_s};

    evr_detect #(.N(N)) u_det (
        .clk(clk), .rst(rst), .lvl(lvl), .cfg(cfg),
        .clr_stb(clr_stb), .set_stb(set_stb),
        .pending(pending), .lat(lat_q), .edge_set(edge_set)
    );

    evr_regs #(.N(N), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .raw(lvl),
        .pending(pending), .cfg(cfg), .clr_stb(clr_stb),
        .set_stb(set_stb), .bus_rdata(bus_rdata)
    );

    always_comb begin
        for (int c = 0; c < N; c++) begin
            irq_en_v[c]  = cfg[c].irq_en;
            wake_en_v[c] = cfg[c].wake_en;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq  <= 1'b0;
            wake <= 1'b0;
        end else begin
            irq  <= |(pending & irq_en_v);
            wake <= |(pending & wake_en_v);
        end
    end
endmodule

// File: rtl/evr_checker.sv
module evr_checker
    import evr_pkg::*;
#(
    parameter int N = 27
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_rd,
    input logic [31:0]       bus_rdata,
    input logic              irq,
    input logic              wake,
    input chan_cfg_t [N-1:0] cfg,
    input logic [N-1:0]      lat,
    input logic [N-1:0]      clr_stb,
    input logic [N-1:0]      edge_set
);
    logic [N-1:0] mask_v, wen_v;

    always_comb begin
        for (int c = 0; c < N; c++) begin
            mask_v[c] = cfg[c].irq_en;
            wen_v[c]  = cfg[c].wake_en;
        end
    end

    // R5: with no channel enabled, irq stays low next cycle
    a_r5_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (mask_v == '0) |=> !irq);

    // R6: with no wake enable, wake stays low next cycle
    a_r6_wake_quiet: assert property (@(posedge clk) disable iff (rst)
        (wen_v == '0) |=> !wake);

    // R4: latched bits only fall on a clear write
    a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
        (clr_stb == '0) |=> ((~lat & $past(lat)) == '0));

    // R8: a new edge beats a simultaneous clear
    a_r8_edge_wins: assert property (@(posedge clk) disable iff (rst)
        (|(clr_stb & edge_set)) |=>
            ((lat & $past(clr_stb & edge_set)) == $past(clr_stb & edge_set)));

    // R9: read data holds without a read strobe
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind event_router evr_checker #(.N(N)) u_chk (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .irq(irq), .wake(wake), .cfg(cfg), .lat(lat_q),
    .clr_stb(clr_stb), .edge_set(edge_set)
);

// File: tb/event_router_test.sv
`timescale 1ns/1ps
module event_router_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] ext_ev = '0;
    logic [2:0]  int_ev = '0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, wake;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    localparam logic [4:0] A_RAW = 5'h00, A_PEND = 5'h04, A_MASK = 5'h08,
        A_POL = 5'h0C, A_MODE = 5'h10, A_CLR = 5'h14, A_SET = 5'h18, A_WAKE = 5'h1C;

    event_router uut (
        .clk(clk), .rst(rst), .ext_ev(ext_ev), .int_ev(int_ev),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .wake(wake)
    );

    always #4 clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        idle(3);
        rst = 1'b0;
        idle(2);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 wake", {31'b0, wake}, 32'h0);
        rd(A_MASK, d); check("R1 mask", d, 32'h0);
        rd(A_POL, d);  check("R1 pol", d, 32'h0);
        rd(A_MODE, d); check("R1 mode", d, 32'h0);
        rd(A_WAKE, d); check("R1 wake_en", d, 32'h0);
    endtask

    task automatic t_raw();
        logic [31:0] d;
        ext_ev = 24'h800001; int_ev = 3'b100;
        idle(4);
        rd(A_RAW, d); check("R2 raw", d, 32'h0480_0001);
        // R9: no read strobe, inputs change, rdata holds
        ext_ev = 24'h000010; int_ev = 3'b000;
        idle(5);
        check("R9 hold", bus_rdata, 32'h0480_0001);
        rd(A_RAW, d); check("R9 reload", d, 32'h0000_0010);
        ext_ev = '0;
        idle(4);
    endtask

    task automatic t_readback();
        logic [31:0] d;
        wr(A_MASK, 32'hFFFF_FFFF);
        rd(A_MASK, d); check("R10 mask", d, 32'h07FF_FFFF);
        wr(A_POL, 32'hA5A5_A5A5);
        rd(A_POL, d); check("R10 pol", d, 32'h05A5_A5A5);
        wr(A_MODE, 32'h1234_5678);
        rd(A_MODE, d); check("R10 mode", d, 32'h0234_5678);
        wr(A_WAKE, 32'h8000_0001);
        rd(A_WAKE, d); check("R10 wake_en", d, 32'h0000_0001);
        wr(A_MASK, 0); wr(A_POL, 0); wr(A_MODE, 0); wr(A_WAKE, 0);
    endtask

    task automatic t_direct();
        logic [31:0] d;
        wr(A_POL, 32'h20);
        wr(A_MASK, 32'h20);
        idle(3);
        check("R3 high idle irq", {31'b0, irq}, 0);
        ext_ev[5] = 1'b1; idle(5);
        check("R3 high active irq", {31'b0, irq}, 1);
        rd(A_PEND, d); check("R3 pend bit5", d & 32'h20, 32'h20);
        ext_ev[5] = 1'b0; idle(5);
        check("R3 drop irq", {31'b0, irq}, 0);
        rd(A_PEND, d); check("R3 pend bit5 drop", d & 32'h20, 0);
        // active low on bit 6
        wr(A_POL, 0); wr(A_MASK, 32'h40);
        idle(3);
        check("R3 low active irq", {31'b0, irq}, 1);
        ext_ev[6] = 1'b1; idle(5);
        check("R3 low inactive irq", {31'b0, irq}, 0);
        wr(A_MASK, 0);
        ext_ev[6] = 1'b0; idle(4);
    endtask

    task automatic t_latched();
        logic [31:0] d;
        wr(A_MODE, 32'h18); wr(A_POL, 32'h08); wr(A_MASK, 32'h08);
        idle(3);
        check("R4 no edge", {31'b0, irq}, 0);
        ext_ev[3] = 1'b1; idle(4); ext_ev[3] = 1'b0; idle(6);
        check("R4 sticky irq", {31'b0, irq}, 1);
        wr(A_CLR, 32'h0); idle(3);
        check("R4 clear zero ignored", {31'b0, irq}, 1);
        // R5: masked bit still pending, irq low
        wr(A_MASK, 0); idle(3);
        check("R5 masked irq", {31'b0, irq}, 0);
        rd(A_PEND, d); check("R5 pend visible", d & 32'h08, 32'h08);
        // R6: wake path on its own enable
        wr(A_WAKE, 32'h08); idle(3);
        check("R6 wake on", {31'b0, wake}, 1);
        check("R6 irq stays off", {31'b0, irq}, 0);
        wr(A_WAKE, 0); wr(A_MASK, 32'h08); idle(3);
        check("R6 wake off", {31'b0, wake}, 0);
        check("R5 unmasked irq", {31'b0, irq}, 1);
        wr(A_CLR, 32'h08); idle(3);
        check("R4 cleared irq", {31'b0, irq}, 0);
        rd(A_PEND, d); check("R4 pend cleared", d & 32'h08, 0);
        // falling-edge capture on bit 4 (polarity 0)
        wr(A_MASK, 32'h10);
        ext_ev[4] = 1'b1; idle(6);
        rd(A_PEND, d); check("R4 rising ignored", d & 32'h10, 0);
        ext_ev[4] = 1'b0; idle(6);
        rd(A_PEND, d); check("R4 falling captured", d & 32'h10, 32'h10);
        check("R4 falling irq", {31'b0, irq}, 1);
        wr(A_CLR, 32'h10); wr(A_MASK, 0); wr(A_MODE, 0); wr(A_POL, 0);
    endtask

    task automatic t_swset();
        logic [31:0] d;
        wr(A_MODE, 32'h0400_0400);
        wr(A_SET, 32'h0400_0400); idle(2);
        rd(A_PEND, d); check("R7 sw set", d & 32'h0400_0400, 32'h0400_0400);
        wr(A_WAKE, 32'h0400_0000); idle(3);
        check("R7 bit26 wake", {31'b0, wake}, 1);
        wr(A_CLR, 32'h0400_0400); idle(3);
        check("R7 cleared wake", {31'b0, wake}, 0);
        wr(A_WAKE, 0); wr(A_MODE, 0);
    endtask

    task automatic t_collision();
        logic [31:0] d;
        wr(A_MODE, 32'h0100_0000); wr(A_POL, 32'h0100_0000);
        @(negedge clk); int_ev[0] = 1'b1;
        @(negedge clk); int_ev[0] = 1'b0;
        idle(2);
        // new rising edge and clear on the same clock edge
        @(negedge clk);
        int_ev[0] = 1'b1;
        bus_addr = A_CLR; bus_wdata = 32'h0100_0000; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(A_PEND, d); check("R8 edge wins", d & 32'h0100_0000, 32'h0100_0000);
        wr(A_CLR, 32'h0100_0000);
        rd(A_PEND, d); check("R8 plain clear", d & 32'h0100_0000, 0);
        int_ev[0] = 1'b0;
        wr(A_MODE, 0); wr(A_POL, 0);
    endtask

    initial begin
        t_reset();
        t_raw();
        t_readback();
        t_direct();
        t_latched();
        t_swset();
        t_collision();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule